// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR-style flash that offers a page read mode. A client hands it one word address at a time over a valid/ready request port. The block drives the memory address bus, chip select and output enable. It then waits a fixed number of clock cycles for the memory's asynchronous access to settle, samples the data bus and returns the word with a one-cycle valid strobe. The memory takes no clock.

The controller remembers which page is open. A page is the group of words that share every address bit above the in-page word offset. When a new request falls inside the open page, it waits only the short in-page access time, T_PAGE cycles. Any other request waits the full first-access time, T_INIT cycles. A designer derives both counts from the memory's nanosecond figures: roughly 70 to 120 ns for the first access and about 25 ns inside a page. The page holds 4 or 8 words, chosen by PAGE_WORDS.

The request port accepts one transfer at a time. `req_ready` is high only while the controller is idle, and that includes the cycle in which `rsp_valid` returns the previous word. A client that holds `req_valid` into that cycle gets back-to-back accesses with chip select held, so the page stays open. The response side has no back-pressure: the client must take `rsp_data` in the cycle that `rsp_valid` is high.

Top module: `pgflash_rd_ctrl`

## Requirements
- R1: During and directly after reset, `rsp_valid` is 0, `req_ready` is 1, `mem_cs_n` is 1, `mem_oe_n` is 1, and no page is open.
- R2: A request that is not a page hit is answered with `rsp_valid` high in the cycle that follows the T_INIT-th rising edge after the accepting edge.
- R3: A request is a page hit when a page is open and `req_addr[ADDR_W-1:OFS]` equals that page's bits. Such a request is answered after T_PAGE edges instead of T_INIT. OFS is 2 when PAGE_WORDS is 4.
- R4: From the accepting edge until the response, `mem_addr` holds the accepted address. `rsp_data` equals the value on `mem_rdata` at the edge that raises `rsp_valid`.
- R5: `rsp_valid` is high for exactly one cycle per accepted request and is never high otherwise.
- R6: `req_ready` is low from the accepting edge until `rsp_valid` rises, and is high in the `rsp_valid` cycle. A request presented while `req_ready` is low is not taken.
- R7: `mem_cs_n` goes low at the accepting edge. It returns high at the first edge where the controller is idle and `req_valid` is low. That edge closes the page, so the next request is a miss.
- R8: `mem_oe_n` is low from the accepting edge until the edge that raises `rsp_valid`, and is high at all other times.
- R9: With PAGE_WORDS = 8 the in-page offset is 3 bits (OFS = 3). Addresses that differ only in bit 2 therefore hit in an 8-word page but miss in a 4-word page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` holds the word |
| rsp_data | output | DATA_W | Returned word |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_rdata | input | DATA_W | Memory data bus |

## Verification
A request accepted at a rising edge has its response strobe due exactly T_INIT edges later on a miss, or T_PAGE edges later on a hit. `req_ready`, `mem_oe_n` and `mem_addr` change at the accepting edge itself. Chip select drops one edge after the idle cycle in which no request is waiting. A behavioural model in the bench advances once per clock from the inputs it sees before each edge. It counts down the remaining cycles with plain integers and compares every output at the following falling edge, so every due cycle is checked in the cycle it falls in and never earlier or later. A 4-word and an 8-word instance run on the same address stream, which makes the page-size difference visible as different latencies.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} pgrd_state_e;

  function automatic int offset_bits(input int page_words);
    return (page_words == 8) ? 3 : 2;
  endfunction
endpackage

// File: rtl/pgrd_page_track.sv
module pgrd_page_track #(
  parameter int PAGE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              close_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o
);
  logic              open_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      page_q <= '0;
    end else if (load_i) begin
      open_q <= 1'b1;
      page_q <= page_i;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  assign hit_o = open_q && (page_q == page_i);

  // R7: a closed page cannot hit on the following cycle
  a_r7_close_kills_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i && !load_i) |=> !hit_o);
endmodule

// File: rtl/pgrd_wait_timer.sv
module pgrd_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == CNT_W'(1));

  // R2: a wait ends exactly once
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/pgflash_rd_ctrl.sv
module pgflash_rd_ctrl #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4,
  parameter int T_INIT     = 10,
  parameter int T_PAGE     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_rdata
);
  import pgrd_pkg::*;

  localparam int OFS_W  = offset_bits(PAGE_WORDS);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int T_MAX  = (T_INIT > T_PAGE) ? T_INIT : T_PAGE;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  pgrd_state_e      state_q;
  logic             accept;
  logic             close_pg;
  logic             hit;
  logic             wait_done;
  logic             cs_q;
  logic             oe_q;
  logic [CNT_W-1:0] lat;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign close_pg  = req_ready && !req_valid;
  assign lat       = hit ? CNT_W'(T_PAGE) : CNT_W'(T_INIT);
  assign mem_cs_n  = !cs_q;
  assign mem_oe_n  = !oe_q;

  pgrd_page_track #(.PAGE_W(PAGE_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .close_i (close_pg),
    .page_i  (req_addr[ADDR_W-1:OFS_W]),
    .hit_o   (hit)
  );

  pgrd_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (lat),
    .done_o     (wait_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_addr  <= '0;
      cs_q      <= 1'b0;
      oe_q      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q  <= ST_WAIT;
            mem_addr <= req_addr;
            cs_q     <= 1'b1;
            oe_q     <= 1'b1;
          end else begin
            cs_q <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (wait_done) begin
            state_q   <= ST_IDLE;
            oe_q      <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_data  <= mem_rdata;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: the data strobe lasts one cycle
  a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R6: returned data coincides with a free request port
  a_r6_ready_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
  // R8: an accepted request opens the output enable and blocks the port
  a_r8_oe_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!mem_oe_n && !req_ready));
  // R7: output enable only under chip select
  a_r7_cs_covers_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_cs_n);
  // R4: address held across the wait
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));
endmodule

// File: tb/pgflash_rd_ctrl_bench.sv
module pgflash_rd_ctrl_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int TI = 10;
  localparam int TP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]    req_valid = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready [2];
  logic          rsp_valid [2];
  logic          mem_cs_n  [2];
  logic          mem_oe_n  [2];
  logic [DW-1:0] rsp_data  [2];
  logic [DW-1:0] mem_rdata [2];
  logic [AW-1:0] mem_addr  [2];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  bit run = 0;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return DW'(a ^ (a >> 5)) ^ 16'hA5C3;
  endfunction

  always_comb begin
    for (int i = 0; i < 2; i++)
      mem_rdata[i] = mem_oe_n[i] ? 16'h0BAD : word_of(mem_addr[i]);
  end

  pgflash_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(4), .T_INIT(TI), .T_PAGE(TP))
  u_pgflash_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_addr(req_addr), .rsp_valid(rsp_valid[0]), .rsp_data(rsp_data[0]),
    .mem_addr(mem_addr[0]), .mem_cs_n(mem_cs_n[0]), .mem_oe_n(mem_oe_n[0]),
    .mem_rdata(mem_rdata[0]));

  pgflash_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(8), .T_INIT(TI), .T_PAGE(TP))
  u_pgflash_rd_ctrl_p8 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_addr(req_addr), .rsp_valid(rsp_valid[1]), .rsp_data(rsp_data[1]),
    .mem_addr(mem_addr[1]), .mem_cs_n(mem_cs_n[1]), .mem_oe_n(mem_oe_n[1]),
    .mem_rdata(mem_rdata[1]));

  task automatic chk(input bit ok, input string tag, input string what, input int i,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s inst%0d %s: actual %0h expected %0h", tag, i, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference state, one set per instance
  bit            m_busy [2];
  int            m_rem  [2];
  bit            m_open [2];
  int            m_page [2];
  bit            m_hit  [2];
  bit            m_cs   [2];
  bit            m_oe   [2];
  bit            m_rsp  [2];
  logic [AW-1:0] m_addr [2];
  logic [DW-1:0] m_data [2];
  bit            acc    [2];

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_busy[i] = 0; m_rem[i] = 0; m_open[i] = 0; m_page[i] = 0; m_hit[i] = 0;
      m_cs[i] = 0; m_oe[i] = 0; m_rsp[i] = 0; m_addr[i] = '0; m_data[i] = '0; acc[i] = 0;
    end
  end

  always @(negedge clk) begin
    if (run && !finished) begin
      for (int i = 0; i < 2; i++) begin
        string lt;
        int ofs;
        ofs = (i == 0) ? 2 : 3;
        lt = m_hit[i] ? ((i == 1) ? "R9" : "R3") : "R2";
        // compare current outputs
        chk(rsp_valid[i] == m_rsp[i], m_rsp[i] ? lt : "R5", "rsp_valid", i,
            longint'(rsp_valid[i]), longint'(m_rsp[i]));
        if (m_rsp[i])
          chk(rsp_data[i] == m_data[i], "R4", "rsp_data", i,
              longint'(rsp_data[i]), longint'(m_data[i]));
        chk(req_ready[i] == !m_busy[i], "R6", "req_ready", i,
            longint'(req_ready[i]), longint'(!m_busy[i]));
        chk(mem_cs_n[i] == !m_cs[i], "R7", "mem_cs_n", i,
            longint'(mem_cs_n[i]), longint'(!m_cs[i]));
        chk(mem_oe_n[i] == !m_oe[i], "R8", "mem_oe_n", i,
            longint'(mem_oe_n[i]), longint'(!m_oe[i]));
        chk(mem_addr[i] == m_addr[i], "R4", "mem_addr", i,
            longint'(mem_addr[i]), longint'(m_addr[i]));
        // advance to the next edge
        acc[i] = 0;
        m_rsp[i] = 0;
        if (!m_busy[i]) begin
          if (req_valid[i]) begin
            m_hit[i]  = m_open[i] && (m_page[i] == int'(req_addr >> ofs));
            m_rem[i]  = m_hit[i] ? TP : TI;
            m_busy[i] = 1;
            m_open[i] = 1;
            m_page[i] = int'(req_addr >> ofs);
            m_addr[i] = req_addr;
            m_cs[i]   = 1;
            m_oe[i]   = 1;
            acc[i]    = 1;
          end else begin
            m_open[i] = 0;
            m_cs[i]   = 0;
          end
        end else begin
          m_rem[i]--;
          if (m_rem[i] == 0) begin
            m_busy[i] = 0;
            m_rsp[i]  = 1;
            m_data[i] = word_of(m_addr[i]);
            m_oe[i]   = 0;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      summary();
    end
  end

  task automatic issue(input logic [AW-1:0] a);
    req_addr = a;
    req_valid = 2'b11;
    while (req_valid != 2'b00) begin
      @(posedge clk);
      #2;
      for (int i = 0; i < 2; i++)
        if (acc[i]) req_valid[i] = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(rsp_valid[i] == 1'b0, "R1", "reset rsp_valid", i, longint'(rsp_valid[i]), 0);
      chk(req_ready[i] == 1'b1, "R1", "reset req_ready", i, longint'(req_ready[i]), 1);
      chk(mem_cs_n[i] == 1'b1, "R1", "reset mem_cs_n", i, longint'(mem_cs_n[i]), 1);
      chk(mem_oe_n[i] == 1'b1, "R1", "reset mem_oe_n", i, longint'(mem_oe_n[i]), 1);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    run = 1;
    #1;
    // R1: the first access after reset is a miss; R3 hits follow back to back
    issue(20'h00100);
    issue(20'h00101);
    issue(20'h00103);
    // R9: offset bit 2 differs; 8-word page hits, 4-word page misses
    issue(20'h00104);
    issue(20'h00107);
    // R7: an idle gap closes the page
    idle(3);
    issue(20'h00105);
    issue(20'h00106);
    // top of the address space and wrap to zero
    issue(20'hFFFF8);
    issue(20'hFFFFB);
    issue(20'hFFFFC);
    issue(20'h00000);
    issue(20'h00002);
    idle(1);
    issue(20'h00003);
    // R6: a request held across a long miss is taken once
    issue(20'h12340);
    issue(20'h12347);
    issue(20'h12341);
    idle(TI + 5);
    finished = 1;
    summary();
  end
endmodule